// File: doc/BRIEF.md
# One-Time-Programmable Array Program and Verify Sequencer

This block programs a byte-wide one-time-programmable (OTP) array without software involvement. It has a parallel array port made of an address, write data, read data and three active-low strobes: chip enable, output enable and program. After a start request it first raises its requests for the elevated core and programming supplies and waits for them to settle. It then walks the array from address 0 upwards. For each byte it holds the address and data, applies a program pulse of one tenth of a millisecond, reads the byte back and compares it with the intended value. A mismatch gets another pulse, up to a bounded number of attempts. A match moves the walk to the next address.

After the last byte both supply requests return to nominal. Once a settle wait has passed, the whole array is read back against the source image. The result is a done flag, a pass flag and the lowest failing address. The bytes to be written come from a source image that the block addresses itself. When the block is idle, a host read port gives access to the array through an address window that starts at a fixed base offset. A security byte, written while the security input is high, closes that port for good, up to the next reset.

Top module: `otp_prog_seq`

## Requirements
- R1: Every program pulse holds `otp_pgm_n` low for exactly PULSE_CYC = CLK_KHZ/10 clock cycles (0.1 ms). During the pulse `otp_ce_n` is low, `otp_oe_n` is high, and `otp_addr` and `otp_wdata` do not change.
- R2: After each pulse the byte is read back and compared with the source byte. On a mismatch another pulse goes to the same address. On a match the walk moves to the next address. Array addresses are programmed in ascending order, starting at 0.
- R3: A byte gets at most MAX_TRY (default 25) pulses, and a byte that matches on the last allowed pulse counts as good. If it still mismatches after MAX_TRY pulses, the run stops with done=1, pass=0 and err_addr set to that address, and no later address is pulsed.
- R4: `vcc_hi_req` and `vpp_hi_req` are both 1 during the whole programming walk and during every pulse. They are both 0 during the final verify and whenever the block is not busy.
- R5: After the last address is matched, and after SETTLE_CYC cycles at nominal supply, every byte is read back against the source image. done then rises with pass=1 if all bytes agree. Otherwise pass=0 and err_addr holds the lowest mismatching address.
- R6: If the byte 8'hFE is matched at array address 0 while `sec_pin` is 1, readout is locked. Every later host read returns 8'hFF and leaves `otp_ce_n` high. If `sec_pin` is 0 when that byte is matched, no lock is set.
- R7: A host read with `rd_addr` in [BASE, BASE+2^ADDR_W) reads array address `rd_addr`-BASE. `rd_valid` is 1 in the cycle after `rd_req`, with the byte on `rd_data`. An address outside that window returns 8'hFF.
- R8: `rd_req` is ignored while `busy` is 1: no `rd_valid` follows.
- R9: Reset drives all three array strobes high and `busy`, `done`, `pass`, `rd_valid` and both supply requests low, and it clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a program and verify run (taken only when idle) |
| sec_pin | input | 1 | Security enable level, sampled when byte 0 matches |
| src_addr | output | ADDR_W | Address into the source image |
| src_data | input | 8 | Source image byte at `src_addr`, combinational |
| otp_addr | output | ADDR_W | Array address |
| otp_wdata | output | 8 | Array write data |
| otp_rdata | input | 8 | Array read data, valid while `otp_ce_n` and `otp_oe_n` are low |
| otp_ce_n | output | 1 | Array chip enable, active low |
| otp_oe_n | output | 1 | Array output enable, active low |
| otp_pgm_n | output | 1 | Array program strobe, active low |
| vcc_hi_req | output | 1 | Request elevated core supply |
| vpp_hi_req | output | 1 | Request programming supply |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished, held until the next start |
| pass | output | 1 | Last run succeeded |
| err_addr | output | ADDR_W | Failing address of the last run |
| rd_req | input | 1 | Host read request |
| rd_addr | input | ADDR_W+2 | Host read address, in the operating-mode window |
| rd_valid | output | 1 | Host read data valid |
| rd_data | output | 8 | Host read data |

## Verification
The assertions assume that the array behaves like real OTP cells: read data is combinational from the address while both enables are low, and the source image holds still during a run. The array model in the bench keeps to these assumptions. It clears bits only on a completed pulse, it needs a per-address number of pulses drawn at random, and it reads out combinationally. Host reads and the start request are driven only away from clock edges. The random image and pulse needs are mixed with directed cases: a byte that needs exactly the maximum number of pulses, one that needs one pulse more, a corruption that appears only after the supply drop, and the security byte written with the security input both high and low.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RAMP,
        S_SETUP,
        S_PULSE,
        S_GAP,
        S_CHECK,
        S_SWITCH,
        S_FINAL
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
    } strobe_t;

    localparam strobe_t STB_OFF  = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1};
    localparam strobe_t STB_SEL  = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b1};
    localparam strobe_t STB_PGM  = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b0};
    localparam strobe_t STB_READ = '{ce_n: 1'b0, oe_n: 1'b0, pgm_n: 1'b1};

    localparam logic [7:0] LOCK_CODE = 8'hFE;
    localparam logic [7:0] BLANK     = 8'hFF;

    // 0.1 ms expressed in clock cycles, never below one cycle
    function automatic int pulse_cycles(input int clk_khz);
        int c;
        c = clk_khz / 10;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_read_port.sv
module otp_read_port #(
    parameter int ADDR_W = 17,
    parameter int MAP_W  = 19,
    parameter int BASE   = 32'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              lock,
    input  logic              rd_req,
    input  logic [MAP_W-1:0]  rd_addr,
    input  logic [7:0]        arr_rdata,
    output logic              arr_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam logic [MAP_W:0] WIN_LO = (MAP_W+1)'(BASE);
    localparam logic [MAP_W:0] WIN_HI = (MAP_W+1)'(BASE + (1 << ADDR_W));

    logic [MAP_W:0] ext_addr;
    logic [MAP_W:0] offs;
    logic           in_win;
    logic           accept;

    assign ext_addr = {1'b0, rd_addr};
    assign offs     = ext_addr - WIN_LO;
    assign in_win   = (ext_addr >= WIN_LO) && (ext_addr < WIN_HI);
    assign accept   = idle && rd_req;
    assign arr_sel  = accept && in_win && !lock;
    assign arr_addr = offs[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= otp_seq_pkg::BLANK;
        end else begin
            rd_valid <= accept;
            if (accept)
                rd_data <= arr_sel ? arr_rdata : otp_seq_pkg::BLANK;
        end
    end
endmodule

// File: rtl/otp_seq_core.sv
module otp_seq_core
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int TW         = 16,
    parameter int PULSE_CYC  = 25000,
    parameter int SETTLE_CYC = 64,
    parameter int MAX_TRY    = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sec_pin,
    input  logic [7:0]        src_data,
    input  logic [7:0]        arr_rdata,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        wdata,
    output strobe_t           strobe,
    output logic              sup_hi,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] err_addr,
    output logic              lock
);
    localparam int                TRY_W     = $clog2(MAX_TRY + 1);
    localparam logic [ADDR_W-1:0] LAST      = '1;
    localparam logic [TW-1:0]     PULSE_LD  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0]     SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TRY_W-1:0]  TRY_LIM   = TRY_W'(MAX_TRY);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [7:0]        data_q, data_d;
    logic [TRY_W-1:0]  tries_q, tries_d;
    logic              done_q, done_d;
    logic              pass_q, pass_d;
    logic              seen_q, seen_d;
    logic              lock_q, lock_d;
    logic              sup_q, sup_d;
    logic [ADDR_W-1:0] err_q, err_d;

    logic prog_match;
    logic final_match;

    assign prog_match  = (arr_rdata == data_q);
    assign final_match = (arr_rdata == src_data);

    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        data_d   = data_q;
        tries_d  = tries_q;
        done_d   = done_q;
        pass_d   = pass_q;
        seen_d   = seen_q;
        lock_d   = lock_q;
        sup_d    = sup_q;
        err_d    = err_q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_RAMP;
                    addr_d   = '0;
                    tries_d  = '0;
                    done_d   = 1'b0;
                    pass_d   = 1'b0;
                    seen_d   = 1'b0;
                    err_d    = '0;
                    sup_d    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
            end
            S_RAMP: begin
                if (tmr_expired)
                    state_d = S_SETUP;
            end
            S_SETUP: begin
                data_d   = src_data;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
                state_d  = S_PULSE;
            end
            S_PULSE: begin
                if (tmr_expired) begin
                    tries_d = tries_q + 1'b1;
                    state_d = S_GAP;
                end
            end
            S_GAP: begin
                state_d = S_CHECK;
            end
            S_CHECK: begin
                if (prog_match) begin
                    if ((addr_q == '0) && (data_q == LOCK_CODE) && sec_pin)
                        lock_d = 1'b1;
                    tries_d = '0;
                    if (addr_q == LAST) begin
                        sup_d    = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = SETTLE_LD;
                        state_d  = S_SWITCH;
                    end else begin
                        addr_d  = addr_q + 1'b1;
                        state_d = S_SETUP;
                    end
                end else if (tries_q >= TRY_LIM) begin
                    done_d  = 1'b1;
                    pass_d  = 1'b0;
                    err_d   = addr_q;
                    sup_d   = 1'b0;
                    state_d = S_IDLE;
                end else begin
                    state_d = S_SETUP;
                end
            end
            S_SWITCH: begin
                if (tmr_expired) begin
                    addr_d  = '0;
                    state_d = S_FINAL;
                end
            end
            S_FINAL: begin
                if (!final_match && !seen_q) begin
                    err_d  = addr_q;
                    seen_d = 1'b1;
                end
                if (addr_q == LAST) begin
                    done_d  = 1'b1;
                    pass_d  = final_match && !seen_q;
                    state_d = S_IDLE;
                end else begin
                    addr_d = addr_q + 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            data_q  <= BLANK;
            tries_q <= '0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            seen_q  <= 1'b0;
            lock_q  <= 1'b0;
            sup_q   <= 1'b0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            tries_q <= tries_d;
            done_q  <= done_d;
            pass_q  <= pass_d;
            seen_q  <= seen_d;
            lock_q  <= lock_d;
            sup_q   <= sup_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        case (state_q)
            S_SETUP, S_GAP:   strobe = STB_SEL;
            S_PULSE:          strobe = STB_PGM;
            S_CHECK, S_FINAL: strobe = STB_READ;
            default:          strobe = STB_OFF;
        endcase
    end

    assign cur_addr = addr_q;
    assign wdata    = data_q;
    assign sup_hi   = sup_q;
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign pass     = pass_q;
    assign err_addr = err_q;
    assign lock     = lock_q;
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int CLK_KHZ    = 250000,
    parameter int SETTLE_CYC = 64,
    parameter int MAX_TRY    = 25,
    parameter int BASE       = 32'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sec_pin,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_data,
    output logic [ADDR_W-1:0] otp_addr,
    output logic [7:0]        otp_wdata,
    input  logic [7:0]        otp_rdata,
    output logic              otp_ce_n,
    output logic              otp_oe_n,
    output logic              otp_pgm_n,
    output logic              vcc_hi_req,
    output logic              vpp_hi_req,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] err_addr,
    input  logic              rd_req,
    input  logic [ADDR_W+1:0] rd_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int MAP_W     = ADDR_W + 2;
    localparam int PULSE_CYC = pulse_cycles(CLK_KHZ);
    localparam int TW        = $clog2(max2(PULSE_CYC, SETTLE_CYC) + 1);

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic [ADDR_W-1:0] core_addr;
    strobe_t           core_stb;
    strobe_t           bus_stb;
    logic              sup_hi;
    logic              lock;
    logic              rp_sel;
    logic [ADDR_W-1:0] rp_addr;

    otp_cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    otp_seq_core #(
        .ADDR_W     (ADDR_W),
        .TW         (TW),
        .PULSE_CYC  (PULSE_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .MAX_TRY    (MAX_TRY)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sec_pin     (sec_pin),
        .src_data    (src_data),
        .arr_rdata   (otp_rdata),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cur_addr    (core_addr),
        .wdata       (otp_wdata),
        .strobe      (core_stb),
        .sup_hi      (sup_hi),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .err_addr    (err_addr),
        .lock        (lock)
    );

    otp_read_port #(
        .ADDR_W (ADDR_W),
        .MAP_W  (MAP_W),
        .BASE   (BASE)
    ) u_rport (
        .clk       (clk),
        .rst       (rst),
        .idle      (!busy),
        .lock      (lock),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .arr_rdata (otp_rdata),
        .arr_sel   (rp_sel),
        .arr_addr  (rp_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // The sequencer owns the array bus while busy, the host port otherwise
    always_comb begin
        if (busy) begin
            bus_stb  = core_stb;
            otp_addr = core_addr;
        end else begin
            bus_stb  = rp_sel ? STB_READ : STB_OFF;
            otp_addr = rp_addr;
        end
    end

    assign otp_ce_n   = bus_stb.ce_n;
    assign otp_oe_n   = bus_stb.oe_n;
    assign otp_pgm_n  = bus_stb.pgm_n;
    assign src_addr   = core_addr;
    assign vcc_hi_req = sup_hi;
    assign vpp_hi_req = sup_hi;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int ADDR_W    = 17,
    parameter int PULSE_CYC = 25000
) (
    input logic              clk,
    input logic              rst,
    input logic              otp_pgm_n,
    input logic              otp_ce_n,
    input logic              otp_oe_n,
    input logic [ADDR_W-1:0] otp_addr,
    input logic [7:0]        otp_wdata,
    input logic              vcc_hi_req,
    input logic              vpp_hi_req,
    input logic              busy,
    input logic              done,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic              lock
);
    int unsigned low_len;

    always_ff @(posedge clk) begin
        if (rst || otp_pgm_n)
            low_len <= 0;
        else
            low_len <= low_len + 1;
    end

    // R1: a pulse only with the array selected and its output off
    a_r1_pgm_strobes: assert property (@(posedge clk) disable iff (rst)
        !otp_pgm_n |-> (!otp_ce_n && otp_oe_n));

    // R1: address and data held through the pulse
    a_r1_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        (!otp_pgm_n && $past(!otp_pgm_n)) |-> ($stable(otp_addr) && $stable(otp_wdata)));

    // R1: exact pulse width
    a_r1_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(otp_pgm_n) |-> (low_len == PULSE_CYC));

    // R4: elevated supplies requested during every pulse
    a_r4_supply_in_pulse: assert property (@(posedge clk) disable iff (rst)
        !otp_pgm_n |-> (vcc_hi_req && vpp_hi_req));

    // R4: nominal supplies whenever not busy
    a_r4_idle_supply: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!vcc_hi_req && !vpp_hi_req));

    // R6: locked readout never shows array data
    a_r6_lock_blank: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && lock) |-> (rd_data == 8'hFF));

    // R8: no host read completes after a busy cycle
    a_r8_busy_no_read: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rd_valid);

    // R3/R5: a finished run is never still busy
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .otp_pgm_n  (otp_pgm_n),
    .otp_ce_n   (otp_ce_n),
    .otp_oe_n   (otp_oe_n),
    .otp_addr   (otp_addr),
    .otp_wdata  (otp_wdata),
    .vcc_hi_req (vcc_hi_req),
    .vpp_hi_req (vpp_hi_req),
    .busy       (busy),
    .done       (done),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .lock       (lock)
);

// File: tb/tb_otp_prog_seq.sv
`timescale 1ns/1ps
module tb_otp_prog_seq;
    localparam int AW     = 5;
    localparam int DEPTH  = 1 << AW;
    localparam int KHZ    = 100;
    localparam int PULSE  = KHZ / 10;
    localparam int SETTLE = 4;
    localparam int TRIES  = 25;
    localparam int BASE   = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          sec_pin;
    logic [AW-1:0] src_addr;
    logic [7:0]    src_data;
    logic [AW-1:0] otp_addr;
    logic [7:0]    otp_wdata;
    logic [7:0]    otp_rdata;
    logic          otp_ce_n, otp_oe_n, otp_pgm_n;
    logic          vcc_hi_req, vpp_hi_req;
    logic          busy, done, pass;
    logic [AW-1:0] err_addr;
    logic          rd_req;
    logic [AW+1:0] rd_addr;
    logic          rd_valid;
    logic [7:0]    rd_data;

    always #2 clk = ~clk;

    otp_prog_seq #(
        .ADDR_W(AW), .CLK_KHZ(KHZ), .SETTLE_CYC(SETTLE), .MAX_TRY(TRIES), .BASE(BASE)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .sec_pin(sec_pin),
        .src_addr(src_addr), .src_data(src_data),
        .otp_addr(otp_addr), .otp_wdata(otp_wdata), .otp_rdata(otp_rdata),
        .otp_ce_n(otp_ce_n), .otp_oe_n(otp_oe_n), .otp_pgm_n(otp_pgm_n),
        .vcc_hi_req(vcc_hi_req), .vpp_hi_req(vpp_hi_req),
        .busy(busy), .done(done), .pass(pass), .err_addr(err_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // ---------------- source image and array model ----------------
    logic [7:0] img  [DEPTH];
    logic [7:0] mem  [DEPTH];
    int         need [DEPTH];
    int         hits [DEPTH];
    int         corrupt_a, corrupt_b;
    logic       mdl_clear;
    int         plen, last_pa, pulse_bad, order_bad, supply_bad;
    logic [AW-1:0] pa;
    logic [7:0]    pd;
    logic          vpp_prev;

    assign src_data  = img[src_addr];
    assign otp_rdata = (!otp_ce_n && !otp_oe_n) ? mem[otp_addr] : 8'hFF;

    always @(posedge clk) begin
        if (mdl_clear) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  <= 8'hFF;
                hits[i] = 0;
            end
            plen = 0; last_pa = 0; pulse_bad = 0; order_bad = 0; supply_bad = 0;
            vpp_prev = 1'b0;
        end else begin
            if (!otp_pgm_n) begin
                plen++;
                pa = otp_addr;
                pd = otp_wdata;
                if (!(vcc_hi_req && vpp_hi_req)) supply_bad++;
                if (otp_ce_n || !otp_oe_n) pulse_bad++;
            end else if (plen > 0) begin
                if (plen != PULSE) pulse_bad++;
                if (int'(pa) < last_pa) order_bad++;
                last_pa = int'(pa);
                hits[pa]++;
                if (hits[pa] >= need[pa]) mem[pa] <= mem[pa] & pd;
                plen = 0;
            end
            if (!otp_ce_n && !otp_oe_n && (vcc_hi_req != vpp_hi_req)) supply_bad++;
            if (vpp_prev && !vpp_hi_req) begin
                if (corrupt_a >= 0) mem[corrupt_a] <= ~img[corrupt_a];
                if (corrupt_b >= 0) mem[corrupt_b] <= ~img[corrupt_b];
            end
            vpp_prev = vpp_hi_req;
        end
    end

    // ---------------- bookkeeping ----------------
    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1; mdl_clear = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; mdl_clear = 1'b0;
    endtask

    task automatic fill_image();
        for (int i = 0; i < DEPTH; i++) begin
            img[i]  = 8'($urandom);
            need[i] = 1 + int'($urandom % 3);
        end
        corrupt_a = -1;
        corrupt_b = -1;
    endtask

    task automatic run_and_wait(output bit ok);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        ok = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic host_read(input int a, output bit v, output logic [7:0] d, output bit ce_seen);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = (AW+2)'(a);
        #1 ce_seen = otp_ce_n;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid;
        d = rd_data;
    endtask

    function automatic int mem_mismatches();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== img[i]) n++;
        return n;
    endfunction

    // ---------------- directed and random sequence ----------------
    initial begin
        bit ok, v, ce;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; sec_pin = 1'b0; rd_req = 1'b0; rd_addr = '0;
        mdl_clear = 1'b1; corrupt_a = -1; corrupt_b = -1;
        for (int i = 0; i < DEPTH; i++) begin img[i] = 8'hFF; need[i] = 1; end
        repeat (3) @(negedge clk);
        rst = 1'b0; mdl_clear = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(otp_ce_n && otp_oe_n && otp_pgm_n, "R9 strobes", {otp_ce_n, otp_oe_n, otp_pgm_n}, 7);
        chk(!busy && !done && !pass && !rd_valid, "R9 status", {busy, done, pass, rd_valid}, 0);
        chk(!vcc_hi_req && !vpp_hi_req, "R9 supplies", {vcc_hi_req, vpp_hi_req}, 0);

        // Case A: random image, multi-pulse byte, security byte with pin low
        fill_image();
        img[0] = 8'hFE; need[5] = 3; sec_pin = 1'b0;
        reset_dut();
        run_and_wait(ok);
        chk(ok, "R5 done A", ok, 1);
        chk(pass, "R5 pass A", pass, 1);
        chk(pulse_bad == 0, "R1 pulse shape A", pulse_bad, 0);
        chk(order_bad == 0, "R2 ascending order A", order_bad, 0);
        chk(supply_bad == 0, "R4 supplies A", supply_bad, 0);
        chk(mem_mismatches() == 0, "R2 array content A", mem_mismatches(), 0);
        chk(hits[5] == 3, "R2 retry count", hits[5], 3);
        chk(!vcc_hi_req && !vpp_hi_req, "R4 nominal after run", {vcc_hi_req, vpp_hi_req}, 0);
        for (int i = 0; i < DEPTH; i++) begin
            host_read(BASE + i, v, d, ce);
            chk(v && d == img[i], "R7 window read", {v, d}, {1'b1, img[i]});
        end
        host_read(BASE - 1, v, d, ce);
        chk(v && d == 8'hFF, "R7 below window", {v, d}, 9'h1FF);
        host_read(BASE + DEPTH, v, d, ce);
        chk(v && d == 8'hFF, "R7 above window", {v, d}, 9'h1FF);
        host_read(BASE, v, d, ce);
        chk(d == 8'hFE && !ce, "R6 no lock with pin low", d, 8'hFE);

        // Case B: byte needing exactly the limit, security pin high
        fill_image();
        img[0] = 8'hFE; need[7] = TRIES; sec_pin = 1'b1;
        reset_dut();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        host_read(BASE + 3, v, d, ce);
        chk(!v, "R8 read while busy", v, 0);
        ok = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        chk(ok && pass, "R3 limit byte passes", {ok, pass}, 3);
        chk(hits[7] == TRIES, "R3 pulses at limit", hits[7], TRIES);
        chk(pulse_bad == 0, "R1 pulse shape B", pulse_bad, 0);
        sec_pin = 1'b0;
        host_read(BASE + 7, v, d, ce);
        chk(v && d == 8'hFF, "R6 locked data", d, 8'hFF);
        chk(ce, "R6 array untouched", ce, 1);
        host_read(BASE, v, d, ce);
        chk(v && d == 8'hFF, "R6 locked byte0", d, 8'hFF);

        // Case C: byte that needs one pulse more than allowed
        fill_image();
        need[9] = TRIES + 1; sec_pin = 1'b0;
        reset_dut();
        run_and_wait(ok);
        chk(ok && !pass, "R3 fail flags", {ok, pass}, 2);
        chk(err_addr == 9, "R3 fail address", err_addr, 9);
        chk(hits[9] == TRIES, "R3 pulses before fail", hits[9], TRIES);
        chk(hits[10] == 0, "R3 no later pulse", hits[10], 0);
        chk(!vcc_hi_req && !vpp_hi_req, "R4 nominal after error", {vcc_hi_req, vpp_hi_req}, 0);

        // Case D: corruption appears only after supply drop
        fill_image();
        corrupt_a = 20; corrupt_b = 12;
        reset_dut();
        run_and_wait(ok);
        chk(ok && !pass, "R5 final fail flags", {ok, pass}, 2);
        chk(err_addr == 12, "R5 lowest failing address", err_addr, 12);
        chk(supply_bad == 0, "R4 supplies D", supply_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule